// File: doc/BRIEF.md
# Multi-Threshold Energy-Bin Counter Bank

This block is the digital back end of a photon-counting linear detector readout. Every data channel has a set of discriminators, one for each energy threshold. The discriminator outputs arrive as asynchronous levels. Each one is synchronised and reduced to a one-cycle pulse on its rising edge. Each pulse advances a dedicated saturating counter, so a channel with five thresholds sorts its hits into five energy bins at once.

Counting is gated by an acquisition window. The window opening clears every counter. Hits are counted only while the window stays open and no readout is running. After a frame, a start pulse launches the readout. A single set bit walks along a one-hot token register, one position per clock. The counter under the token is placed on a shared parallel bus together with a valid strobe. A done flag rises with the last word.

All 160 counters are read in 160 consecutive clocks. At 200 MHz this takes well under the 20 µs the frame budget allows.

Top module: `ebin_counter_bank`

## Requirements
- R1: Each discriminator input passes through a two-stage synchroniser. A counter advances exactly once per 0-to-1 transition of its input. A level held high adds nothing further.
- R2: A counter advances only while `acq_win` is high, the window is past its first cycle, and no readout is running. Transitions while `acq_win` is low are ignored.
- R3: A counter that holds all ones (2^CNT_W - 1) stays there on further hits and never wraps.
- R4: The clock in which `acq_win` is first seen high clears every counter to zero and clears `rd_done`.
- R5: Hits that arrive while `rd_busy` is high are not counted, neither during the readout nor afterwards.
- R6: A `rd_start` pulse while idle raises `rd_busy` on the next clock. It then produces exactly N_CH*N_BIN words on consecutive clocks, each marked by `bus_valid`. The first word appears one clock after `rd_busy` rises. Word k is counter k, where k = channel*N_BIN + bin, and input bit k of `cmp_in` feeds counter k.
- R7: A `rd_start` pulse while `rd_busy` is high is ignored: the running readout neither restarts nor lengthens.
- R8: `rd_done` rises in the same clock as the last word, together with `rd_busy` falling. It stays high until the next accepted `rd_start` or window opening.
- R9: After reset, `bus_valid`, `rd_busy` and `rd_done` are low and every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_in | input | N_CH*N_BIN | Asynchronous discriminator levels, bit k = channel*N_BIN + bin |
| acq_win | input | 1 | Acquisition window, high while counting is allowed |
| rd_start | input | 1 | One-clock pulse that starts a readout |
| bus_data | output | CNT_W | Counter value under the token |
| bus_valid | output | 1 | Marks a valid word on `bus_data` |
| rd_busy | output | 1 | Readout in progress |
| rd_done | output | 1 | Last counter has been read |

## Verification
A wrong token position shows at once as words out of order on the bus. A lost or doubled token shows as a word count other than N_CH*N_BIN between `rd_start` and `rd_done`. Counter faults show only at the next readout: a missed clear, a wrap at full scale, or a count taken during readout or outside the window leaves a word that differs from the bench's tally. Readouts therefore follow every stimulus phase, so each fault surfaces within one frame.

// File: rtl/ebin_pkg.sv
package ebin_pkg;
  localparam int unsigned EB_CHANNELS = 32;
  localparam int unsigned EB_BINS     = 5;
  localparam int unsigned EB_CNT_W    = 16;
endpackage

// File: rtl/ebin_sync_edge.sv
module ebin_sync_edge #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;

  // R1: an edge pulse never lasts two cycles
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/ebin_counter.sv
module ebin_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] FULL = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && cnt != FULL)
      cnt <= cnt + 1'b1;
  end

  // R3: full scale is sticky until a clear
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == FULL && !clr) |=> cnt == FULL);
  // R1: at most one step per clock
  a_r1_step_one: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ebin_token_seq.sv
module ebin_token_seq #(
  parameter int unsigned N_CNT = 160,
  parameter int unsigned CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   acq_start,
  input  logic [N_CNT*CNT_W-1:0] cnt_flat,
  output logic [CNT_W-1:0]       bus_data,
  output logic                   bus_valid,
  output logic                   busy,
  output logic                   done
);
  logic [N_CNT-1:0] token;
  logic [CNT_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < int'(N_CNT); i++)
      if (token[i]) sel = sel | cnt_flat[i*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      token     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      bus_valid <= 1'b0;
      bus_data  <= '0;
    end else begin
      bus_valid <= 1'b0;
      if (busy) begin
        bus_data  <= sel;
        bus_valid <= 1'b1;
        token     <= {token[N_CNT-2:0], 1'b0};
        if (token[N_CNT-1]) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        busy  <= 1'b1;
        token <= {{(N_CNT-1){1'b0}}, 1'b1};
        done  <= 1'b0;
      end
      if (acq_start) done <= 1'b0;
    end
  end

  // R6: never more than one counter on the bus
  a_r6_token_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(token));
  // R6: first word follows busy rising by one clock
  a_r6_first_word: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> bus_valid);
  // R8: done rises exactly as busy falls
  a_r8_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));
  // R6: no word outside a readout
  a_r6_valid_in_read: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> $past(busy));
endmodule

// File: rtl/ebin_counter_bank.sv
module ebin_counter_bank #(
  parameter int unsigned N_CH  = ebin_pkg::EB_CHANNELS,
  parameter int unsigned N_BIN = ebin_pkg::EB_BINS,
  parameter int unsigned CNT_W = ebin_pkg::EB_CNT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_CH*N_BIN-1:0] cmp_in,
  input  logic                  acq_win,
  input  logic                  rd_start,
  output logic [CNT_W-1:0]      bus_data,
  output logic                  bus_valid,
  output logic                  rd_busy,
  output logic                  rd_done
);
  localparam int unsigned N_CNT = N_CH * N_BIN;

  logic [N_CNT-1:0]       rise;
  logic [N_CNT*CNT_W-1:0] cnt_flat;
  logic                   win_q;
  logic                   acq_start;
  logic                   count_ok;

  always_ff @(posedge clk) begin
    if (rst) win_q <= 1'b0;
    else     win_q <= acq_win;
  end

  assign acq_start = acq_win & ~win_q;
  assign count_ok  = acq_win & win_q & ~rd_busy;

  ebin_sync_edge #(.WIDTH(N_CNT)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (cmp_in),
    .rise     (rise)
  );

  for (genvar ch = 0; ch < int'(N_CH); ch++) begin : g_ch
    for (genvar b = 0; b < int'(N_BIN); b++) begin : g_bin
      localparam int unsigned IDX = ch * N_BIN + b;
      ebin_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (acq_start),
        .inc (rise[IDX] & count_ok),
        .cnt (cnt_flat[IDX*CNT_W +: CNT_W])
      );
    end
  end

  ebin_token_seq #(.N_CNT(N_CNT), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (rd_start),
    .acq_start (acq_start),
    .cnt_flat  (cnt_flat),
    .bus_data  (bus_data),
    .bus_valid (bus_valid),
    .busy      (rd_busy),
    .done      (rd_done)
  );

  // R5: counters frozen while a readout runs
  a_r5_frozen_in_read: assert property (@(posedge clk) disable iff (rst)
    (rd_busy && !acq_start) |=> $stable(cnt_flat));
  // R4: window opening clears every counter
  a_r4_open_clears: assert property (@(posedge clk) disable iff (rst)
    acq_start |=> cnt_flat == '0);
  // R2: nothing counts with the window shut
  a_r2_closed_hold: assert property (@(posedge clk) disable iff (rst)
    !acq_win |=> $stable(cnt_flat));
endmodule

// File: tb/tb_ebin_counter_bank.sv
module tb_ebin_counter_bank;
  localparam int NCH = 32;
  localparam int NB  = 5;
  localparam int CW  = 10;
  localparam int NC  = NCH * NB;
  localparam int FULL = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] cmp_in = '0;
  logic          acq_win = 1'b0;
  logic          rd_start = 1'b0;
  logic [CW-1:0] bus_data;
  logic          bus_valid, rd_busy, rd_done;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int exp_cnt [NC];
  logic [NC-1:0] prev_v = '0;

  always #2.5 clk = ~clk;

  ebin_counter_bank #(.N_CH(NCH), .N_BIN(NB), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .acq_win(acq_win),
    .rd_start(rd_start), .bus_data(bus_data), .bus_valid(bus_valid),
    .rd_busy(rd_busy), .rd_done(rd_done)
  );

  task automatic check(input string req, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int sat_inc(input int v);
    return (v >= FULL) ? FULL : v + 1;
  endfunction

  // mode 0: random on all bits; mode 1: bit 7 toggles every cycle, rest sparse
  task automatic drive(input int n, input int mode, input bit counted);
    for (int j = 0; j < n; j++) begin
      logic [NC-1:0] v;
      @(negedge clk);
      for (int k = 0; k < NC / 32; k++) v[k*32 +: 32] = $urandom();
      if (mode == 1) begin
        v = v & {NC/32{32'h0100_0001}};
        v[7] = j[0];
      end
      if (counted)
        for (int b = 0; b < NC; b++)
          if (v[b] && !prev_v[b]) exp_cnt[b] = sat_inc(exp_cnt[b]);
      cmp_in = v;
      prev_v = v;
    end
  endtask

  task automatic quiet(input int n);
    @(negedge clk);
    cmp_in = '0;
    prev_v = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic open_window();
    @(negedge clk);
    acq_win = 1'b1;
    for (int b = 0; b < NC; b++) exp_cnt[b] = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic close_window();
    @(negedge clk);
    acq_win = 1'b0;
    @(negedge clk);
  endtask

  // R6 R8: full readout compared with the model
  task automatic readout(input string tag);
    int got = 0;
    int guard = 0;
    @(negedge clk);
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    check({tag, " R6 busy after start"}, int'(rd_busy), 1);
    check({tag, " R8 done cleared by start"}, int'(rd_done), 0);
    @(negedge clk);
    check({tag, " R6 first word timing"}, int'(bus_valid), 1);
    while (!rd_done && guard < 400) begin
      if (bus_valid) begin
        if (got < NC) check({tag, " R6 word value"}, int'(bus_data), exp_cnt[got]);
        got++;
      end
      guard++;
      @(negedge clk);
    end
    if (bus_valid) got++;
    check({tag, " R6 word count"}, got, NC);
    check({tag, " R8 busy low at done"}, int'(rd_busy), 0);
    @(negedge clk);
    check({tag, " R8 done held"}, int'(rd_done), 1);
    check({tag, " R6 valid ends"}, int'(bus_valid), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < NC; b++) exp_cnt[b] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 valid", int'(bus_valid), 0);
    check("R9 busy", int'(rd_busy), 0);
    check("R9 done", int'(rd_done), 0);
    readout("R9 zero counters");

    // R1 R2: random frame, then edges with window shut
    open_window();
    drive(300, 0, 1'b1);
    quiet(4);
    close_window();
    drive(60, 0, 1'b0);
    quiet(4);
    readout("R1 R2 frame");

    // R5 R7: edges during readout ignored, extra start ignored
    open_window();
    drive(200, 0, 1'b1);
    quiet(4);
    @(negedge clk);
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    begin
      int words = 0;
      for (int j = 0; j < 90; j++) begin
        logic [NC-1:0] v;
        if (bus_valid) words++;
        for (int k = 0; k < NC / 32; k++) v[k*32 +: 32] = $urandom();
        cmp_in = v;
        rd_start = (j == 40);
        @(negedge clk);
      end
      cmp_in = '0;
      prev_v = '0;
      rd_start = 1'b0;
      while (!rd_done && words < 400) begin
        if (bus_valid) words++;
        @(negedge clk);
      end
      if (bus_valid) words++;
      check("R7 start ignored while busy, word count", words, NC);
    end
    repeat (4) @(negedge clk);
    readout("R5 no count during readout");
    close_window();

    // R4: reopen with no edges clears all
    open_window();
    quiet(6);
    check("R4 done cleared by window open", int'(rd_done), 0);
    close_window();
    readout("R4 cleared");

    // R3: saturation on bit 7
    open_window();
    drive(2 * FULL + 200, 1, 1'b1);
    quiet(4);
    close_window();
    check("R3 model saturated", exp_cnt[7], FULL);
    readout("R3 saturate");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule